// File: doc/BRIEF.md
# Selector-Tree Boolean Function Generator

This block produces one output bit that can follow any Boolean function of `NVARS` input variables. It does not store a lookup of 2^n entries. It keeps a selector with 2^(n-1) data rows. The upper n-1 variables form the row index. Each row is fed by a small source that outputs one of four values: constant 0, constant 1, the lowest variable (called the residual), or the inverse of the residual. A 2-bit code per row picks that value, so a full function costs 2^n configuration bits. The data still flows through a selector of half the usual width.

The selector is a cascade. Stages of 4:1 consume the select bits two at a time, starting from the least significant end. When the number of select bits is odd, one 2:1 stage driven by the most significant select bit finishes the tree. The whole path is combinational: a change on any input appears on the output with no clock.

To realize a function from its truth table, take each pair of rows that differ only in the residual, with the residual at 0 and then at 1. The pair maps to a code as follows:
- (0,0) gives constant 0.
- (1,1) gives constant 1.
- (0,1) gives the residual.
- (1,0) gives the inverse of the residual.

Top module: `mux_fgen`

## Requirements
- R1: `vars_i[NVARS-1:1]` is the row index, with `vars_i[NVARS-1]` as its most significant bit. `vars_i[0]` is the residual variable. `func_o` carries the value produced by the indexed row.
- R2: A row whose code (`cfg_i[2r+1:2r]` for row r) is 2'b00 drives 0 when it is selected.
- R3: A row whose code is 2'b01 drives 1 when it is selected.
- R4: A row whose code is 2'b10 drives the residual `vars_i[0]` when it is selected.
- R5: A row whose code is 2'b11 drives the inverse of `vars_i[0]` when it is selected.
- R6: With NVARS=3 and row codes {11,11,00,01} for rows 0..3 (`cfg_i` = 8'b01001111), `func_o` is 1 exactly for input values 0, 2, 6 and 7.
- R7: For every NVARS from 2 to 5, any truth table converted to row codes with the pair rule above is reproduced on `func_o` for all 2^NVARS input values.
- R8: `func_o` follows changes on `vars_i` and `cfg_i` with no clock and holds no state.
- R9: The codes of rows that are not selected have no effect on `func_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vars_i | input | NVARS | Function variables; the upper bits index a row, bit 0 is the residual |
| cfg_i | input | 2*2^(NVARS-1) | Per-row source codes, row r at bits [2r+1:2r] |
| func_o | output | 1 | Function value |

## Verification
The inline assertions assume that `vars_i` and `cfg_i` are 2-state and stable when they are evaluated. They also assume that `NVARS` lies in the range 2 to 5, so that the index always falls inside the configuration vector. The bench meets these assumptions in three ways:
- It drives every input with known values from time zero.
- It changes inputs only on the falling clock edge.
- It samples one nanosecond later, after the combinational path has settled.

It instantiates only the sizes 2, 3, 4 and 5, so both tree shapes are covered: the one that ends in a 2:1 stage and the one built only from 4:1 stages.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_VAR  = 2'b10,
    SRC_NVAR = 2'b11
  } src_code_e;

  // first node index of tree level k in a flat node vector
  function automatic int level_base(input int rows, input int k);
    int b;
    b = 0;
    for (int i = 0; i < k; i++) b += rows >> (2 * i);
    return b;
  endfunction

  // total nodes across leaf level and all 4:1 levels
  function automatic int tree_nodes(input int rows, input int quads);
    return level_base(rows, quads + 1);
  endfunction

endpackage

// File: rtl/fgen_row_src.sv
module fgen_row_src
  import fgen_pkg::*;
(
  input  src_code_e code_i,
  input  logic      x_i,
  output logic      y_o
);

  always_comb begin
    unique case (code_i)
      SRC_ZERO: y_o = 1'b0;
      SRC_ONE:  y_o = 1'b1;
      SRC_VAR:  y_o = x_i;
      SRC_NVAR: y_o = ~x_i;
      default:  y_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/fgen_sel4.sv
module fgen_sel4 (
  input  logic [3:0] d_i,
  input  logic [1:0] s_i,
  output logic       y_o
);

  always_comb begin
    unique case (s_i)
      2'd0:    y_o = d_i[0];
      2'd1:    y_o = d_i[1];
      2'd2:    y_o = d_i[2];
      default: y_o = d_i[3];
    endcase
  end

endmodule

// File: rtl/fgen_sel2.sv
module fgen_sel2 (
  input  logic [1:0] d_i,
  input  logic       s_i,
  output logic       y_o
);

  assign y_o = s_i ? d_i[1] : d_i[0];

endmodule

// File: rtl/fgen_tree.sv
module fgen_tree
  import fgen_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] leaf_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  y_o
);

  localparam int ROWS     = 1 << SEL_W;
  localparam int QUADS    = SEL_W / 2;
  localparam int HAS_PAIR = SEL_W % 2;
  localparam int TOT      = tree_nodes(ROWS, QUADS);
  localparam int LAST_B   = level_base(ROWS, QUADS);

  logic [TOT-1:0] node;

  assign node[ROWS-1:0] = leaf_i;

  // 4:1 levels, each using the next two select bits from the LSB end
  for (genvar k = 0; k < QUADS; k++) begin : g_lvl
    localparam int IN_B  = level_base(ROWS, k);
    localparam int OUT_B = level_base(ROWS, k + 1);
    localparam int CNT   = ROWS >> (2 * (k + 1));
    for (genvar j = 0; j < CNT; j++) begin : g_node
      fgen_sel4 u_sel4 (
        .d_i (node[IN_B + 4*j +: 4]),
        .s_i (sel_i[2*k +: 2]),
        .y_o (node[OUT_B + j])
      );
    end
  end

  // odd select count: last 2:1 stage on the MSB
  if (HAS_PAIR != 0) begin : g_pair
    fgen_sel2 u_sel2 (
      .d_i (node[LAST_B +: 2]),
      .s_i (sel_i[SEL_W-1]),
      .y_o (y_o)
    );
  end else begin : g_root
    assign y_o = node[LAST_B];
  end

endmodule

// File: rtl/mux_fgen.sv
module mux_fgen
  import fgen_pkg::*;
#(
  parameter int NVARS = 4
) (
  input  logic [NVARS-1:0]               vars_i,
  input  logic [2*(1<<(NVARS-1))-1:0]    cfg_i,
  output logic                           func_o
);

  localparam int SEL_W = NVARS - 1;
  localparam int ROWS  = 1 << SEL_W;

  logic             residual;
  logic [SEL_W-1:0] row_sel;
  logic [ROWS-1:0]  leaf;

  assign residual = vars_i[0];
  assign row_sel  = vars_i[NVARS-1:1];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    fgen_row_src u_src (
      .code_i (src_code_e'(cfg_i[2*r +: 2])),
      .x_i    (residual),
      .y_o    (leaf[r])
    );
  end

  fgen_tree #(.SEL_W(SEL_W)) u_tree (
    .leaf_i (leaf),
    .sel_i  (row_sel),
    .y_o    (func_o)
  );

  // code of the row addressed by the select variables, taken straight
  // from the configuration port and compared with the tree output
  logic [1:0] picked_code;
  always_comb picked_code = cfg_i[2*row_sel +: 2];

  always_comb begin
    if (picked_code == 2'b00)
      assert_zero_row_R2: assert (func_o == 1'b0)
        else $error("row code 00 did not give 0");
    if (picked_code == 2'b01)
      assert_one_row_R3: assert (func_o == 1'b1)
        else $error("row code 01 did not give 1");
    if (picked_code == 2'b10)
      assert_var_row_R4: assert (func_o == residual)
        else $error("row code 10 did not pass the residual");
    if (picked_code == 2'b11)
      assert_nvar_row_R5: assert (func_o == ~residual)
        else $error("row code 11 did not invert the residual");
  end

endmodule

// File: tb/tb_mux_fgen.sv
module tb_mux_fgen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [3:0]  v4;  logic [15:0] c4;  logic y4;
  logic [2:0]  v3;  logic [7:0]  c3;  logic y3;
  logic [4:0]  v5;  logic [31:0] c5;  logic y5;
  logic [1:0]  v2;  logic [3:0]  c2;  logic y2;

  mux_fgen #(.NVARS(4)) dut   (.vars_i(v4), .cfg_i(c4), .func_o(y4));
  mux_fgen #(.NVARS(3)) dut3  (.vars_i(v3), .cfg_i(c3), .func_o(y3));
  mux_fgen #(.NVARS(5)) dut5  (.vars_i(v5), .cfg_i(c5), .func_o(y5));
  mux_fgen #(.NVARS(2)) dut2  (.vars_i(v2), .cfg_i(c2), .func_o(y2));

  // {cfg[7:0], vars[2:0], expected} for the 3-variable instance
  localparam int NVEC = 14;
  localparam logic [11:0] VEC [NVEC] = '{
    {8'b01001111, 3'd0, 1'b1}, {8'b01001111, 3'd1, 1'b0},
    {8'b01001111, 3'd2, 1'b1}, {8'b01001111, 3'd3, 1'b0},
    {8'b01001111, 3'd4, 1'b0}, {8'b01001111, 3'd5, 1'b0},
    {8'b01001111, 3'd6, 1'b1}, {8'b01001111, 3'd7, 1'b1},
    {8'b00000000, 3'd5, 1'b0}, {8'b01010101, 3'd2, 1'b1},
    {8'b10101010, 3'd3, 1'b1}, {8'b10101010, 3'd6, 1'b0},
    {8'b11111111, 3'd4, 1'b1}, {8'b11111111, 3'd1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tt_to_cfg(input logic [31:0] tt, input int rows);
    logic [31:0] c;
    c = '0;
    for (int r = 0; r < rows; r++) begin
      case ({tt[2*r+1], tt[2*r]})
        2'b00: c[2*r +: 2] = 2'b00;
        2'b11: c[2*r +: 2] = 2'b01;
        2'b10: c[2*r +: 2] = 2'b10;
        default: c[2*r +: 2] = 2'b11;
      endcase
    end
    return c;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    v4 = '0; c4 = '0; v3 = '0; c3 = '0;
    v5 = '0; c5 = '0; v2 = '0; c2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // all-zero configuration gives 0 everywhere (R2)
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); v4 = v[3:0]; #1;
      check("R2 zero config", y4, 1'b0);
    end

    // vector table, 3-variable instance (R6, R1, R3, R4, R5)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      c3 = VEC[i][11:4]; v3 = VEC[i][3:1]; #1;
      if (i < 8) check("R6 example function", y3, VEC[i][0]);
      else       check("R1 R3 R4 R5 row codes", y3, VEC[i][0]);
    end

    // random truth tables on every size (R7, R1)
    for (int it = 0; it < 20; it++) begin
      logic [31:0] t2, t3, t4, t5;
      t2 = $urandom & 32'hF;    t3 = $urandom & 32'hFF;
      t4 = $urandom & 32'hFFFF; t5 = $urandom;
      @(negedge clk);
      c2 = tt_to_cfg(t2, 2)[3:0];  c3 = tt_to_cfg(t3, 4)[7:0];
      c4 = tt_to_cfg(t4, 8)[15:0]; c5 = tt_to_cfg(t5, 16);
      for (int v = 0; v < 32; v++) begin
        @(negedge clk);
        v2 = v[1:0]; v3 = v[2:0]; v4 = v[3:0]; v5 = v[4:0]; #1;
        check("R7 n=5 truth table", y5, t5[v]);
        if (v < 16) check("R7 n=4 truth table", y4, t4[v]);
        if (v < 8)  check("R7 n=3 truth table", y3, t3[v]);
        if (v < 4)  check("R7 n=2 truth table", y2, t2[v]);
      end
    end

    // unselected rows have no effect (R9): row 5 fixed, others random
    for (int it = 0; it < 10; it++) begin
      @(negedge clk);
      c4 = $urandom; c4[11:10] = 2'b01; v4 = 4'b1010; #1;
      check("R9 other rows ignored, code 01", y4, 1'b1);
      c4 = $urandom; c4[11:10] = 2'b00; #1;
      check("R9 other rows ignored, code 00", y4, 1'b0);
    end

    // combinational response with no clock edge between (R8)
    @(negedge clk);
    c4 = '0; c4[15:14] = 2'b10; v4 = 4'b1110; #1;
    check("R8 follows residual=0", y4, 1'b0);
    v4 = 4'b1111; #1;
    check("R8 follows residual=1", y4, 1'b1);
    c4[15:14] = 2'b11; #1;
    check("R8 follows config change", y4, 1'b0);

    // MSB selects upper half (R1): only row 4 of n=4 set to 1
    @(negedge clk);
    c4 = '0; c4[9:8] = 2'b01; v4 = 4'b1000; #1;
    check("R1 MSB index row 4", y4, 1'b1);
    v4 = 4'b0001; #1;
    check("R1 MSB clear row 0", y4, 1'b0);

    done = 1'b1;
    summary();
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

endmodule